// File: doc/BRIEF.md
# Scalar Single-Precision Compare-to-Flags Unit

This block compares two IEEE-754 single-precision numbers and reports the outcome in the integer condition flags of the core. Each source is a wide vector register. Only the lowest 32-bit lane of each source takes part in the compare. A one-cycle strobe presents the operands together with the current SIMD control/status word. One cycle later the block returns the new condition flags, its sticky exception status and a trap request.

The compare is an ordered one. Any NaN, whether quiet or signaling, makes the pair unordered and raises the invalid-operation condition. A subnormal operand raises the denormal-operand condition. The exception status bits accumulate: a compare can set them but cannot clear them. If a raised condition is not masked in the control word, the block requests a trap. In that case it leaves the condition flags untouched, so the trap handler sees the flags as they were before the faulting compare.

Top module: `sfcmp_flag_unit`

## Requirements
- R1: Only bits 31:0 of `src_a` and `src_b` are used. Changing any higher bit never changes any output.
- R2: On an untrapped result, the flags are written as follows, with `flags_o` bit 3 = zero, bit 1 = parity and bit 0 = carry. Unordered gives zero=1, parity=1, carry=1. A greater than B gives 0,0,0. A less than B gives 0,0,1. Equal gives 1,0,0. The order is the ordinary numeric order, with infinities at the ends.
- R3: On an untrapped result, `flags_o` bit 5 (overflow), bit 4 (sign) and bit 2 (auxiliary carry) are written as 0.
- R4: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. Fraction bit 22 set means quiet; clear means signaling. A NaN in either operand sets `exc_stat_o` bit 0 (invalid).
- R5: An operand is subnormal when its exponent is zero and its fraction is nonzero. A subnormal in either operand sets `exc_stat_o` bit 1 (denormal).
- R6: +0 and -0 compare as equal to each other and to themselves.
- R7: `ctl_word` bit 7 masks invalid and bit 8 masks denormal. When a raised condition has its mask bit at 0, `trap_o` is 1 together with `out_valid` and `flags_o` keeps its previous value. Otherwise `trap_o` is 0. The exception status is still updated on a trapped compare.
- R8: `exc_stat_o` bits are sticky. Only reset clears them.
- R9: Reset clears all outputs. `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. Outputs other than `out_valid` and `trap_o` change only with a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| src_a | input | SRC_W (128) | First source register; low lane used |
| src_b | input | SRC_W (128) | Second source register; low lane used |
| ctl_word | input | CTL_W (16) | SIMD control word; bits 7 and 8 are exception masks |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| flags_o | output | 6 | Condition flags {overflow, sign, zero, aux, parity, carry} |
| exc_stat_o | output | 2 | Sticky status {denormal, invalid} |
| trap_o | output | 1 | Unmasked exception trap request |

## Verification
The hardest situation to reach is a trapped compare whose held flags can be told apart from the flags it would have written. Reaching it needs a nonzero, non-reset flag state first, followed by a NaN or subnormal under a cleared mask. To get there, the bench streams every pair from a 16-value set of classes back to back under each of the four mask patterns. It does this without resets, so each trapped vector follows an ordinary compare that left distinct flags. A second pass resets before every pair, so the invalid and denormal status can be checked alone for each pair despite being sticky.

// File: rtl/sfcmp_pkg.sv
package sfcmp_pkg;

    typedef enum logic [1:0] {
        ORD_UNORD = 2'd0,
        ORD_GT    = 2'd1,
        ORD_LT    = 2'd2,
        ORD_EQ    = 2'd3
    } order_e;

    typedef struct packed {
        logic is_nan;
        logic is_snan;
        logic is_sub;
        logic is_zero;
    } fp_class_t;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } cond_flags_t;

    function automatic cond_flags_t encode_order(order_e ord);
        cond_flags_t f;
        f = '0;
        unique case (ord)
            ORD_UNORD: begin f.zro = 1'b1; f.par = 1'b1; f.cry = 1'b1; end
            ORD_GT:    begin f.zro = 1'b0; f.par = 1'b0; f.cry = 1'b0; end
            ORD_LT:    begin f.zro = 1'b0; f.par = 1'b0; f.cry = 1'b1; end
            default:   begin f.zro = 1'b1; f.par = 1'b0; f.cry = 1'b0; end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sfcmp_classify.sv
module sfcmp_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0]  op,
    output sfcmp_pkg::fp_class_t  cls
);
    localparam int FP_W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] frac_f;
    logic             exp_ones;
    logic             exp_zero;
    logic             frac_nz;

    always_comb begin
        exp_f    = op[FP_W-2 -: EXP_W];
        frac_f   = op[MAN_W-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        frac_nz  = |frac_f;

        cls.is_nan  = exp_ones & frac_nz;
        cls.is_snan = exp_ones & frac_nz & ~frac_f[MAN_W-1];
        cls.is_sub  = exp_zero & frac_nz;
        cls.is_zero = exp_zero & ~frac_nz;
    end
endmodule

// File: rtl/sfcmp_order.sv
module sfcmp_order #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0]  op_a,
    input  logic [EXP_W+MAN_W:0]  op_b,
    input  sfcmp_pkg::fp_class_t  cls_a,
    input  sfcmp_pkg::fp_class_t  cls_b,
    output sfcmp_pkg::order_e     ord
);
    import sfcmp_pkg::*;

    localparam int FP_W  = 1 + EXP_W + MAN_W;
    localparam int MAG_W = FP_W - 1;

    logic             sgn_a;
    logic             sgn_b;
    logic [MAG_W-1:0] mag_a;
    logic [MAG_W-1:0] mag_b;
    logic             a_above;

    always_comb begin
        sgn_a = op_a[FP_W-1];
        sgn_b = op_b[FP_W-1];
        mag_a = op_a[MAG_W-1:0];
        mag_b = op_b[MAG_W-1:0];

        // sign-magnitude ordering: different signs -> positive wins;
        // same sign -> magnitude order, reversed for negatives
        if (sgn_a != sgn_b) begin
            a_above = ~sgn_a;
        end else if (!sgn_a) begin
            a_above = (mag_a > mag_b);
        end else begin
            a_above = (mag_a < mag_b);
        end

        if (cls_a.is_nan || cls_b.is_nan) begin
            ord = ORD_UNORD;
        end else if (cls_a.is_zero && cls_b.is_zero) begin
            ord = ORD_EQ;
        end else if (op_a == op_b) begin
            ord = ORD_EQ;
        end else if (a_above) begin
            ord = ORD_GT;
        end else begin
            ord = ORD_LT;
        end
    end
endmodule

// File: rtl/sfcmp_flag_unit.sv
module sfcmp_flag_unit #(
    parameter int SRC_W  = 128,
    parameter int EXP_W  = 8,
    parameter int MAN_W  = 23,
    parameter int CTL_W  = 16,
    parameter int INV_MASK_BIT = 7,
    parameter int DEN_MASK_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] src_a,
    input  logic [SRC_W-1:0] src_b,
    input  logic [CTL_W-1:0] ctl_word,
    output logic             out_valid,
    output logic [5:0]       flags_o,
    output logic [1:0]       exc_stat_o,
    output logic             trap_o
);
    import sfcmp_pkg::*;

    localparam int FP_W = 1 + EXP_W + MAN_W;
    localparam int N_OP = 2;

    typedef struct packed {
        logic        vld;
        cond_flags_t flags;
        logic [1:0]  stat;
        logic        trap;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [FP_W-1:0] lane   [N_OP];
    fp_class_t       cls    [N_OP];
    order_e          ord;
    logic            raise_inv;
    logic            raise_den;
    logic            unmasked;

    assign lane[0] = src_a[FP_W-1:0];
    assign lane[1] = src_b[FP_W-1:0];

    for (genvar gi = 0; gi < N_OP; gi++) begin : g_cls
        sfcmp_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
        ) u_cls (
            .op  (lane[gi]),
            .cls (cls[gi])
        );
    end

    sfcmp_order #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) u_ord (
        .op_a  (lane[0]),
        .op_b  (lane[1]),
        .cls_a (cls[0]),
        .cls_b (cls[1]),
        .ord   (ord)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_valid;
        st_d.trap = 1'b0;

        raise_inv = cls[0].is_nan | cls[1].is_nan;
        raise_den = cls[0].is_sub | cls[1].is_sub;
        unmasked  = (raise_inv & ~ctl_word[INV_MASK_BIT])
                  | (raise_den & ~ctl_word[DEN_MASK_BIT]);

        if (in_valid) begin
            st_d.stat = st_q.stat | {raise_den, raise_inv};
            st_d.trap = unmasked;
            if (!unmasked) begin
                st_d.flags = encode_order(ord);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign flags_o    = st_q.flags;
    assign exc_stat_o = st_q.stat;
    assign trap_o     = st_q.trap;

endmodule

// File: rtl/sfcmp_flag_unit_chk.sv
module sfcmp_flag_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic [5:0] flags_o,
    input logic [1:0] exc_stat_o,
    input logic       trap_o
);
    AST_RESULT_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9

    AST_NO_RESULT_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9

    AST_FLAGS_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(flags_o)); // R9

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((exc_stat_o & $past(exc_stat_o)) == $past(exc_stat_o))); // R8

    AST_TRAP_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $stable(flags_o)); // R7

    AST_TRAP_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> out_valid); // R7

    AST_SIDE_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !trap_o) |-> (flags_o[5] == 1'b0 && flags_o[4] == 1'b0 && flags_o[2] == 1'b0)); // R3

    AST_LEGAL_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !trap_o) |-> (flags_o[1] == (flags_o[3] & flags_o[0]))); // R2
endmodule

bind sfcmp_flag_unit sfcmp_flag_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .flags_o    (flags_o),
    .exc_stat_o (exc_stat_o),
    .trap_o     (trap_o)
);

// File: tb/sfcmp_flag_unit_test.sv
module sfcmp_flag_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [15:0]  ctl_word = '0;
    logic         out_valid;
    logic [5:0]   flags_o;
    logic [1:0]   exc_stat_o;
    logic         trap_o;

    int unsigned n_vec  = 0;
    int unsigned n_miss = 0;
    bit          done   = 1'b0;

    logic [5:0]  m_flags;
    logic [1:0]  m_stat;
    logic        m_trap;

    always #5 clk = ~clk;

    sfcmp_flag_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .src_a      (src_a),
        .src_b      (src_b),
        .ctl_word   (ctl_word),
        .out_valid  (out_valid),
        .flags_o    (flags_o),
        .exc_stat_o (exc_stat_o),
        .trap_o     (trap_o)
    );

    function automatic logic [31:0] sample_val(int idx);
        case (idx)
            0:  return 32'h0000_0000; // +0
            1:  return 32'h8000_0000; // -0
            2:  return 32'h0000_0001; // smallest subnormal
            3:  return 32'h807F_FFFF; // largest negative subnormal
            4:  return 32'h0080_0000; // smallest normal
            5:  return 32'h3F80_0000; // 1.0
            6:  return 32'hBF80_0000; // -1.0
            7:  return 32'h3FC0_0000; // 1.5
            8:  return 32'h4000_0000; // 2.0
            9:  return 32'hC000_0000; // -2.0
            10: return 32'h7F7F_FFFF; // largest finite
            11: return 32'h7F80_0000; // +inf
            12: return 32'hFF80_0000; // -inf
            13: return 32'h7FC0_0000; // quiet NaN
            14: return 32'h7F80_0001; // signaling NaN
            default: return 32'hFFFF_FFFF; // negative quiet NaN
        endcase
    endfunction

    function automatic bit is_nan32(logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic bit is_sub32(logic [31:0] v);
        return (v[30:23] == 8'h00) && (v[22:0] != 0);
    endfunction

    function automatic real to_real(logic [31:0] v);
        real mag;
        int  e;
        e = int'(v[30:23]);
        if (e == 0)
            mag = real'(v[22:0]) * (2.0 ** (-149));
        else if (e == 255)
            mag = 1.0e300;
        else
            mag = (1.0 + real'(v[22:0]) / 8388608.0) * (2.0 ** (e - 127));
        return v[31] ? -mag : mag;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        if (!ok) begin
            n_miss++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive one compare at a falling edge, check its result one cycle later
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [15:0] ctl);
        bit  inv, den, trp;
        real ra, rb;
        logic [2:0] zpc;
        src_a    = {$urandom, $urandom, $urandom, a};
        src_b    = {$urandom, $urandom, $urandom, b};
        ctl_word = ctl;
        in_valid = 1'b1;

        inv = is_nan32(a) || is_nan32(b);
        den = is_sub32(a) || is_sub32(b);
        trp = (inv && !ctl[7]) || (den && !ctl[8]);
        ra  = to_real(a);
        rb  = to_real(b);
        if (inv)          zpc = 3'b111;
        else if (ra > rb) zpc = 3'b000;
        else if (ra < rb) zpc = 3'b001;
        else              zpc = 3'b100;
        m_stat = m_stat | {den, inv};
        m_trap = trp;
        if (!trp) m_flags = {1'b0, 1'b0, zpc[2], 1'b0, zpc[1], zpc[0]};

        @(negedge clk);
        in_valid = 1'b0;
        n_vec++;
        check(out_valid == 1'b1, "R9", "out_valid after strobe", 8'(out_valid), 8'd1);
        check({flags_o[3], flags_o[1], flags_o[0]} == {m_flags[3], m_flags[1], m_flags[0]},
              "R1/R2", "zero/parity/carry", 8'({flags_o[3], flags_o[1], flags_o[0]}),
              8'({m_flags[3], m_flags[1], m_flags[0]}));
        check({flags_o[5], flags_o[4], flags_o[2]} == {m_flags[5], m_flags[4], m_flags[2]},
              "R3", "overflow/sign/aux", 8'({flags_o[5], flags_o[4], flags_o[2]}),
              8'({m_flags[5], m_flags[4], m_flags[2]}));
        check(exc_stat_o[0] == m_stat[0], "R4", "invalid status", 8'(exc_stat_o[0]), 8'(m_stat[0]));
        check(exc_stat_o[1] == m_stat[1], "R5", "denormal status", 8'(exc_stat_o[1]), 8'(m_stat[1]));
        check(trap_o == m_trap, "R7", "trap request", 8'(trap_o), 8'(m_trap));
    endtask

    task automatic idle_check();
        @(negedge clk);
        n_vec++;
        check(out_valid == 1'b0, "R9", "out_valid idle", 8'(out_valid), 8'd0);
        check(flags_o == m_flags, "R9", "flags idle hold", 8'(flags_o), 8'(m_flags));
        check(trap_o == 1'b0, "R7", "trap idle", 8'(trap_o), 8'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        rst_n   = 1'b1;
        m_flags = '0;
        m_stat  = '0;
        m_trap  = 1'b0;
    endtask

    initial begin
        m_flags = '0;
        m_stat  = '0;
        m_trap  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        check({out_valid, trap_o, exc_stat_o, flags_o} == 10'd0, "R9", "reset state",
              8'({out_valid, trap_o, exc_stat_o}), 8'd0);

        // signed zeros, all masked (R6)
        apply(32'h0000_0000, 32'h8000_0000, 16'h0180);
        check(flags_o == 6'b001000, "R6", "+0 vs -0 equal", 8'(flags_o), 8'h08);
        apply(32'h8000_0000, 32'h8000_0000, 16'h0180);
        check(flags_o == 6'b001000, "R6", "-0 vs -0 equal", 8'(flags_o), 8'h08);

        // upper bits differ, same low lane -> same result (R1)
        apply(32'h3F80_0000, 32'h4000_0000, 16'h0180);
        check(flags_o == 6'b000001, "R1", "upper bits ignored", 8'(flags_o), 8'h01);
        idle_check();

        // per-pair status with reset in between, all exceptions masked
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                do_reset();
                apply(sample_val(i), sample_val(j), 16'h0180 | 16'($urandom) & 16'hFE7F);
            end
        end

        // streaming under each mask pattern; sticky and trap-hold behaviour
        for (int m = 0; m < 4; m++) begin
            do_reset();
            // seed a nonzero flag state (less-than -> carry)
            apply(32'hBF80_0000, 32'h3F80_0000, 16'h0180);
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    apply(sample_val(i), sample_val(j),
                          (16'($urandom) & 16'hFE7F) | {7'd0, m[1], m[0], 7'd0});
                    n_vec++;
                    check((exc_stat_o & m_stat) == m_stat, "R8", "sticky status",
                          8'(exc_stat_o), 8'(m_stat));
                end
                if (i % 5 == 0) idle_check();
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

endmodule